// File: doc/BRIEF.md
# ADC Regular-Group Conversion Sequencer

This block is the digital controller for the regular conversion group of an analog-to-digital converter. A conversion run is launched either by a software start pulse or by a qualified edge on one of two external trigger inputs. Once launched, the block walks a programmed list of channels and issues one conversion request at a time to an abstract converter. Requests use a valid/ready handshake. The converter answers each accepted request with a one-cycle result strobe. The block right-aligns each result to the selected resolution and places it in an output data register. Software reads that register through a valid/ready stream port. Results that arrive before the previous one has been read are handled under a selectable overrun policy.

A mode register selects the trigger source and polarity, the single, continuous or discontinuous sequencing mode, the chunk size for discontinuous runs, the overrun policy and the resolution. Writes to this register take effect only while the block is idle. The sequence length and the channel numbers come in on separate configuration inputs.

The output stream follows valid/ready rules. `dout_valid` stays high and `dout_data` stays in place until the cycle in which `dout_ready` is also high. The converter side cannot be stalled, so back-pressure on the output stream never delays a conversion. It only leads to an overrun.

Top module: `adc_regseq`

## Requirements
- R1: After reset, `busy`, `conv_req_valid`, `dout_valid` and `ovr_flag` are 0, and `cfg_rd` reads all zeros.
- R2: The trigger mode field `cfg[1:0]` sets the start source. With 0, a `sw_start` pulse starts a run. With 1, a rising edge starts a run; with 2, a falling edge; with 3, either edge. The edge is taken on the external input picked by `cfg[2]`, after a two-flop synchronizer. With a nonzero mode, `sw_start` is ignored. Edges on the unselected input are also ignored.
- R3: While `busy` is high, the block keeps at most one request outstanding. It walks positions 0 to `seq_len_m1`. Position n requests the channel held in `seq_chans[5n+4:5n]`, and every result is delivered with that channel number.
- R4: With `cfg[3]` (continuous) at 0 and `cfg[4]` at 0, `busy` clears after the result for the last position. With `cfg[3]` at 1, the run restarts at position 0 with no new start, and keeps going until stopped.
- R5: With `cfg[4]` (discontinuous) at 1, each start converts a chunk of `cfg[7:5]`+1 channels, or fewer if the last position is reached first. `busy` then clears. The next start resumes at the following position and wraps to position 0 after the last one.
- R6: A write that sets both `cfg[3]` and `cfg[4]` is refused as a whole, and `cfg_rd` keeps its previous value.
- R7: A `cfg_we` write is ignored while `busy` is high or a request is outstanding. Otherwise the write takes effect on the next edge.
- R8: If a result arrives while `dout_valid` is high and no read occurs in that cycle, `ovr_flag` sets and stays set until an `ovr_clr` pulse. With `cfg[8]` at 0, the old data is kept. With `cfg[8]` at 1, the new result replaces it. If a new overrun and a clear happen in the same cycle, the flag stays set.
- R9: The resolution field `cfg[10:9]` selects 14, 12, 10 or 8 bits for codes 0 to 3. `dout_data` equals the converter result shifted right by twice the code.
- R10: A `sw_stop` pulse clears `busy` and returns the position to 0. A request that is already outstanding still delivers its result.
- R11: `dout_valid` holds, with `dout_data` unchanged unless an overwrite overrun occurs, until `dout_ready` is high. After that handshake it drops, unless a new result arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 11 | Mode register write value |
| cfg_rd | output | 11 | Mode register contents |
| sw_start | input | 1 | Software start pulse |
| sw_stop | input | 1 | Software stop pulse |
| ext_trig | input | 2 | Asynchronous external trigger inputs |
| seq_len_m1 | input | 4 | Sequence length minus one |
| seq_chans | input | 80 | Sixteen 5-bit channel numbers, position 0 in the low bits |
| conv_req_valid | output | 1 | Conversion request valid |
| conv_req_ready | input | 1 | Converter accepts the request |
| conv_req_chan | output | 5 | Channel of the request |
| conv_res_valid | input | 1 | One-cycle result strobe from the converter |
| conv_res_data | input | 14 | Raw 14-bit result |
| dout_valid | output | 1 | Data register holds an unread result |
| dout_ready | input | 1 | Reader takes the result |
| dout_data | output | 14 | Right-aligned result |
| dout_chan | output | 5 | Channel of the result |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Clears the overrun flag |
| busy | output | 1 | Regular start flag |

## Verification
The assertions assume that the converter raises `conv_res_valid` only while a request it accepted is still unanswered, and exactly once per accepted request. Under that assumption, a result strobe seen together with an unread, unaccepted data register always means a real overrun. The bench's converter model keeps to this rule by construction: it takes one request, waits a fixed latency, strobes one result and then looks for the next request. All stimulus changes just after a rising edge, so the assertions and the scoreboard see stable inputs.

// File: rtl/adc_regseq_pkg.sv
package adc_regseq_pkg;
  localparam int CFG_W   = 11;
  localparam int CHUNK_W = 3;
  localparam int NTRIG   = 2;
  localparam int SEL_W   = $clog2(NTRIG);

  typedef enum logic [1:0] {
    TRG_SOFT = 2'd0,
    TRG_RISE = 2'd1,
    TRG_FALL = 2'd2,
    TRG_BOTH = 2'd3
  } trg_mode_e;

  typedef struct packed {
    logic [1:0]         res_code;
    logic               ovr_over;
    logic [CHUNK_W-1:0] chunk_m1;
    logic               disc;
    logic               cont;
    logic [SEL_W-1:0]   trig_pick;
    trg_mode_e          trg_mode;
  } mode_cfg_t;
endpackage

// File: rtl/adc_regseq_trig.sv
module adc_regseq_trig #(
  parameter int NTRIG  = 2,
  parameter int STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NTRIG-1:0]         trig_in,
  input  logic [$clog2(NTRIG)-1:0] pick,
  input  adc_regseq_pkg::trg_mode_e mode,
  output logic                     hit
);
  import adc_regseq_pkg::*;

  logic [NTRIG-1:0] now_lv, old_lv;

  for (genvar i = 0; i < NTRIG; i++) begin : g_in
    logic [STAGES-1:0] sh;
    logic              prv;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh  <= '0;
        prv <= 1'b0;
      end else begin
        sh  <= {sh[STAGES-2:0], trig_in[i]};
        prv <= sh[STAGES-1];
      end
    end
    assign now_lv[i] = sh[STAGES-1];
    assign old_lv[i] = prv;
  end

  logic rise, fall;
  assign rise = now_lv[pick] & ~old_lv[pick];
  assign fall = ~now_lv[pick] & old_lv[pick];

  always_comb begin
    unique case (mode)
      TRG_RISE: hit = rise;
      TRG_FALL: hit = fall;
      TRG_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_regseq_cfg.sv
module adc_regseq_cfg (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  adc_regseq_pkg::mode_cfg_t  wval,
  input  logic                       lock,
  output adc_regseq_pkg::mode_cfg_t  cfg_q
);
  logic accept;
  assign accept = we && !lock && !(wval.cont && wval.disc);

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (accept) cfg_q <= wval;
  end
endmodule

// File: rtl/adc_regseq_ctl.sv
module adc_regseq_ctl #(
  parameter int CH_W    = 5,
  parameter int SEQ_MAX = 16,
  parameter int CHUNK_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cont,
  input  logic                       disc,
  input  logic [CHUNK_W-1:0]         chunk_m1,
  input  logic                       hw_en,
  input  logic                       hw_hit,
  input  logic                       sw_start,
  input  logic                       sw_stop,
  input  logic [$clog2(SEQ_MAX)-1:0] len_m1,
  input  logic [SEQ_MAX*CH_W-1:0]    chans,
  output logic                       req_valid,
  input  logic                       req_ready,
  output logic [CH_W-1:0]            req_chan,
  input  logic                       res_valid,
  output logic                       res_take,
  output logic [CH_W-1:0]            cur_chan,
  output logic                       busy_q,
  output logic                       waiting_q
);
  localparam int POS_W = $clog2(SEQ_MAX);

  logic [POS_W-1:0]   pos;
  logic [CHUNK_W-1:0] ccnt;
  logic start_ok, last, chunk_end;

  assign start_ok  = !busy_q && !waiting_q && (hw_en ? hw_hit : sw_start);
  assign res_take  = waiting_q && res_valid;
  assign last      = (pos == len_m1);
  assign chunk_end = (ccnt == chunk_m1) || last;
  assign req_valid = busy_q && !waiting_q;
  assign req_chan  = chans[pos*CH_W +: CH_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      waiting_q <= 1'b0;
      pos       <= '0;
      ccnt      <= '0;
      cur_chan  <= '0;
    end else begin
      if (start_ok) begin
        busy_q <= 1'b1;
        ccnt   <= '0;
      end
      if (req_valid && req_ready) begin
        waiting_q <= 1'b1;
        cur_chan  <= req_chan;
      end
      if (res_take) begin
        waiting_q <= 1'b0;
        if (busy_q) begin
          pos <= last ? '0 : pos + 1'b1;
          if (disc) begin
            ccnt <= chunk_end ? '0 : ccnt + 1'b1;
            if (chunk_end) busy_q <= 1'b0;
          end else if (last && !cont) begin
            busy_q <= 1'b0;
          end
        end
      end
      if (sw_stop) begin
        busy_q <= 1'b0;
        pos    <= '0;
        ccnt   <= '0;
      end
    end
  end
endmodule

// File: rtl/adc_regseq_dreg.sv
module adc_regseq_dreg #(
  parameter int RAW_W = 14,
  parameter int CH_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             new_res,
  input  logic [RAW_W-1:0] raw,
  input  logic [CH_W-1:0]  chan,
  input  logic [1:0]       res_code,
  input  logic             ovr_over,
  input  logic             rd_ready,
  input  logic             ovr_clr,
  output logic             rd_valid,
  output logic [RAW_W-1:0] rd_data,
  output logic [CH_W-1:0]  rd_chan,
  output logic             ovr_q
);
  logic [RAW_W-1:0] aligned;
  logic rd_fire;
  assign aligned = raw >> {res_code, 1'b0};
  assign rd_fire = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_chan  <= '0;
      ovr_q    <= 1'b0;
    end else begin
      if (ovr_clr) ovr_q <= 1'b0;
      if (new_res) begin
        if (!rd_valid || rd_fire) begin
          rd_valid <= 1'b1;
          rd_data  <= aligned;
          rd_chan  <= chan;
        end else begin
          ovr_q <= 1'b1;
          if (ovr_over) begin
            rd_data <= aligned;
            rd_chan <= chan;
          end
        end
      end else if (rd_fire) begin
        rd_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_regseq.sv
module adc_regseq #(
  parameter int CH_W    = 5,
  parameter int SEQ_MAX = 16,
  parameter int RAW_W   = 14,
  parameter int SYNC_N  = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_we,
  input  logic [adc_regseq_pkg::CFG_W-1:0]    cfg_wdata,
  output logic [adc_regseq_pkg::CFG_W-1:0]    cfg_rd,
  input  logic                                sw_start,
  input  logic                                sw_stop,
  input  logic [adc_regseq_pkg::NTRIG-1:0]    ext_trig,
  input  logic [$clog2(SEQ_MAX)-1:0]          seq_len_m1,
  input  logic [SEQ_MAX*CH_W-1:0]             seq_chans,
  output logic                                conv_req_valid,
  input  logic                                conv_req_ready,
  output logic [CH_W-1:0]                     conv_req_chan,
  input  logic                                conv_res_valid,
  input  logic [RAW_W-1:0]                    conv_res_data,
  output logic                                dout_valid,
  input  logic                                dout_ready,
  output logic [RAW_W-1:0]                    dout_data,
  output logic [CH_W-1:0]                     dout_chan,
  output logic                                ovr_flag,
  input  logic                                ovr_clr,
  output logic                                busy
);
  import adc_regseq_pkg::*;

  mode_cfg_t       cfg_q;
  logic            waiting, hw_hit, res_take;
  logic [CH_W-1:0] cur_chan;

  assign cfg_rd = cfg_q;

  adc_regseq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wval(mode_cfg_t'(cfg_wdata)),
    .lock(busy || waiting), .cfg_q(cfg_q)
  );

  adc_regseq_trig #(.NTRIG(NTRIG), .STAGES(SYNC_N)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(ext_trig), .pick(cfg_q.trig_pick),
    .mode(cfg_q.trg_mode), .hit(hw_hit)
  );

  adc_regseq_ctl #(.CH_W(CH_W), .SEQ_MAX(SEQ_MAX), .CHUNK_W(CHUNK_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cont(cfg_q.cont), .disc(cfg_q.disc),
    .chunk_m1(cfg_q.chunk_m1), .hw_en(cfg_q.trg_mode != TRG_SOFT),
    .hw_hit(hw_hit), .sw_start(sw_start), .sw_stop(sw_stop),
    .len_m1(seq_len_m1), .chans(seq_chans), .req_valid(conv_req_valid),
    .req_ready(conv_req_ready), .req_chan(conv_req_chan),
    .res_valid(conv_res_valid), .res_take(res_take), .cur_chan(cur_chan),
    .busy_q(busy), .waiting_q(waiting)
  );

  adc_regseq_dreg #(.RAW_W(RAW_W), .CH_W(CH_W)) u_dreg (
    .clk(clk), .rst_n(rst_n), .new_res(res_take), .raw(conv_res_data),
    .chan(cur_chan), .res_code(cfg_q.res_code), .ovr_over(cfg_q.ovr_over),
    .rd_ready(dout_ready), .ovr_clr(ovr_clr), .rd_valid(dout_valid),
    .rd_data(dout_data), .rd_chan(dout_chan), .ovr_q(ovr_flag)
  );
endmodule

// File: rtl/adc_regseq_chk.sv
module adc_regseq_chk #(
  parameter int RAW_W = 14,
  parameter int CFG_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_rd,
  input logic             busy,
  input logic             conv_req_valid,
  input logic             conv_req_ready,
  input logic             conv_res_valid,
  input logic             dout_valid,
  input logic             dout_ready,
  input logic [RAW_W-1:0] dout_data,
  input logic             ovr_flag
);
  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_rd)); // R7
  AST_NO_CONT_DISC: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_rd[3] && cfg_rd[4])); // R6
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_valid && conv_req_ready |=> !conv_req_valid); // R3
  AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid && !dout_ready && conv_res_valid |=> ovr_flag); // R8
  AST_OVR_KEEP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid && !dout_ready && conv_res_valid && !cfg_rd[8] |=> $stable(dout_data)); // R8
  AST_HOLD_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid && !dout_ready |=> dout_valid); // R11
  AST_ALIGN_8BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_valid) && $past(cfg_rd[10:9]) == 2'b11 |-> dout_data[RAW_W-1:8] == '0); // R9
endmodule

bind adc_regseq adc_regseq_chk #(.RAW_W(RAW_W), .CFG_W(adc_regseq_pkg::CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .busy(busy),
  .conv_req_valid(conv_req_valid), .conv_req_ready(conv_req_ready),
  .conv_res_valid(conv_res_valid), .dout_valid(dout_valid),
  .dout_ready(dout_ready), .dout_data(dout_data), .ovr_flag(ovr_flag)
);

// File: tb/adc_regseq_bench.sv
`timescale 1ns/1ps
module adc_regseq_bench;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [10:0] cfg_wdata, cfg_rd;
  logic        sw_start, sw_stop;
  logic [1:0]  ext_trig;
  logic [3:0]  seq_len_m1;
  logic [79:0] seq_chans;
  logic        conv_req_valid, conv_req_ready;
  logic [4:0]  conv_req_chan;
  logic        conv_res_valid;
  logic [13:0] conv_res_data;
  logic        dout_valid, dout_ready;
  logic [13:0] dout_data;
  logic [4:0]  dout_chan;
  logic        ovr_flag, ovr_clr, busy;

  always #2 clk = ~clk;

  adc_regseq u_adc_regseq (.*);

  int n_cmp = 0, n_bad = 0;
  logic [4:0]  exp_ch[$];
  logic [13:0] exp_d[$];

  function automatic logic [13:0] raw_of(logic [4:0] ch);
    return 14'((int'(ch) * 613 + 1000) % 16384);
  endfunction

  function automatic logic [10:0] mk(logic [1:0] res, logic over, logic [2:0] chunk,
                                     logic disc, logic cont, logic sel, logic [1:0] mode);
    return {res, over, chunk, disc, cont, sel, mode};
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(logic [4:0] ch, logic [1:0] res);
    exp_ch.push_back(ch);
    exp_d.push_back(raw_of(ch) >> (2 * res));
  endtask

  task automatic write_cfg(logic [10:0] w);
    cfg_wdata = w; cfg_we = 1'b1; tick(1); cfg_we = 1'b0;
  endtask

  task automatic pulse_start();
    sw_start = 1'b1; tick(1); sw_start = 1'b0;
  endtask

  task automatic wait_idle(string tag);
    tick(4);
    for (int k = 0; k < 400; k++) begin
      if (!busy && exp_ch.size() == 0) break;
      tick(1);
    end
    tick(LAT + 3);
    check(busy == 1'b0, tag, "busy after run", busy, 0);
    check(exp_ch.size() == 0, tag, "results still expected", exp_ch.size(), 0);
  endtask

  // converter model: one request at a time, fixed latency
  initial begin
    conv_res_valid = 1'b0;
    conv_res_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && conv_req_valid && conv_req_ready) begin
        logic [4:0] ch;
        ch = conv_req_chan;
        repeat (LAT) @(posedge clk);
        #1;
        conv_res_valid = 1'b1;
        conv_res_data  = raw_of(ch);
        @(posedge clk);
        #1;
        conv_res_valid = 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && dout_valid && dout_ready) begin
      if (exp_ch.size() == 0) begin
        check(1'b0, "R3", "unexpected result chan", dout_chan, -1);
      end else begin
        logic [4:0]  ec;
        logic [13:0] ed;
        ec = exp_ch.pop_front();
        ed = exp_d.pop_front();
        check(dout_chan == ec, "R3", "result channel", dout_chan, ec);
        check(dout_data == ed, "R9", "result data", dout_data, ed);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R3", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int base;
    logic [10:0] saved;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; sw_start = 1'b0; sw_stop = 1'b0;
    ext_trig = '0; seq_len_m1 = '0; seq_chans = '0; conv_req_ready = 1'b1;
    dout_ready = 1'b1; ovr_clr = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    check(busy == 0, "R1", "busy", busy, 0);
    check(conv_req_valid == 0, "R1", "req valid", conv_req_valid, 0);
    check(dout_valid == 0, "R1", "dout valid", dout_valid, 0);
    check(ovr_flag == 0, "R1", "ovr flag", ovr_flag, 0);
    check(cfg_rd == 0, "R1", "cfg", cfg_rd, 0);

    // R4 single pass, 14-bit
    seq_len_m1 = 4'd3;
    seq_chans[4:0] = 5'd3; seq_chans[9:5] = 5'd7; seq_chans[14:10] = 5'd12; seq_chans[19:15] = 5'd31;
    push(3, 0); push(7, 0); push(12, 0); push(31, 0);
    pulse_start();
    wait_idle("R4");

    // R9 8-bit and 12-bit resolution
    write_cfg(mk(2'd3, 0, 0, 0, 0, 0, 0));
    check(cfg_rd == mk(2'd3, 0, 0, 0, 0, 0, 0), "R7", "idle write taken", cfg_rd, mk(2'd3, 0, 0, 0, 0, 0, 0));
    push(3, 3); push(7, 3); push(12, 3); push(31, 3);
    pulse_start();
    wait_idle("R9");
    write_cfg(mk(2'd1, 0, 0, 0, 0, 0, 0));
    push(3, 1); push(7, 1); push(12, 1); push(31, 1);
    pulse_start();
    wait_idle("R9");

    // R7 write locked during run
    write_cfg(mk(2'd0, 0, 0, 0, 0, 0, 0));
    saved = cfg_rd;
    push(3, 0); push(7, 0); push(12, 0); push(31, 0);
    pulse_start();
    tick(2);
    write_cfg(mk(2'd3, 1, 3'd5, 0, 0, 1, 2'd1));
    check(cfg_rd == saved, "R7", "cfg during run", cfg_rd, saved);
    wait_idle("R7");

    // R6 illegal combination refused
    write_cfg(mk(2'd2, 1, 3'd2, 1, 1, 1, 2'd3));
    check(cfg_rd == saved, "R6", "cont+disc write", cfg_rd, saved);

    // R4 continuous, then R10 stop
    write_cfg(mk(2'd0, 0, 0, 0, 1, 0, 0));
    for (int p = 0; p < 3; p++) begin
      push(3, 0); push(7, 0); push(12, 0); push(31, 0);
    end
    base = n_cmp;
    pulse_start();
    for (int k = 0; k < 2000; k++) begin
      if (n_cmp - base >= 20) break;
      tick(1);
    end
    sw_stop = 1'b1; tick(1); sw_stop = 1'b0;
    tick(20);
    check(busy == 0, "R10", "busy after stop", busy, 0);
    check(n_cmp - base >= 20, "R4", "continuous restarted (checks)", n_cmp - base, 20);
    exp_ch.delete(); exp_d.delete();
    write_cfg(mk(2'd0, 0, 0, 0, 0, 0, 0));
    push(3, 0); push(7, 0); push(12, 0); push(31, 0);
    pulse_start();
    wait_idle("R10");

    // R5 discontinuous, chunk of 2, five channels
    seq_len_m1 = 4'd4;
    seq_chans[4:0] = 5'd1; seq_chans[9:5] = 5'd2; seq_chans[14:10] = 5'd3;
    seq_chans[19:15] = 5'd4; seq_chans[24:20] = 5'd5;
    write_cfg(mk(2'd0, 0, 3'd1, 1, 0, 0, 0));
    push(1, 0); push(2, 0); pulse_start(); wait_idle("R5");
    push(3, 0); push(4, 0); pulse_start(); wait_idle("R5");
    push(5, 0); pulse_start(); wait_idle("R5");
    push(1, 0); push(2, 0); pulse_start(); wait_idle("R5");

    // R2 hardware triggers
    seq_len_m1 = 4'd0; seq_chans[4:0] = 5'd9;
    sw_stop = 1'b1; tick(1); sw_stop = 1'b0;
    write_cfg(mk(2'd0, 0, 0, 0, 0, 1, 2'd1));
    ext_trig[0] = 1'b1; tick(8);
    check(busy == 0, "R2", "unselected input edge", busy, 0);
    ext_trig[0] = 1'b0; tick(4);
    pulse_start(); tick(6);
    check(busy == 0, "R2", "sw start in hw mode", busy, 0);
    push(9, 0); ext_trig[1] = 1'b1; wait_idle("R2");
    write_cfg(mk(2'd0, 0, 0, 0, 0, 1, 2'd2));
    push(9, 0); ext_trig[1] = 1'b0; wait_idle("R2");
    ext_trig[1] = 1'b1; tick(8);
    check(busy == 0, "R2", "rise in falling mode", busy, 0);
    write_cfg(mk(2'd0, 0, 0, 0, 0, 1, 2'd3));
    push(9, 0); ext_trig[1] = 1'b0; wait_idle("R2");
    push(9, 0); ext_trig[1] = 1'b1; wait_idle("R2");

    // R8 / R11 overrun, keep old data
    write_cfg(mk(2'd0, 0, 0, 0, 0, 0, 0));
    seq_len_m1 = 4'd1; seq_chans[4:0] = 5'd4; seq_chans[9:5] = 5'd6;
    dout_ready = 1'b0;
    push(4, 0);
    pulse_start();
    tick(30);
    check(ovr_flag == 1, "R8", "overrun flag", ovr_flag, 1);
    check(dout_valid == 1, "R11", "valid held", dout_valid, 1);
    check(dout_data == raw_of(4), "R8", "kept old data", dout_data, raw_of(4));
    dout_ready = 1'b1; tick(2);
    check(dout_valid == 0, "R11", "valid after read", dout_valid, 0);
    check(ovr_flag == 1, "R8", "flag sticky", ovr_flag, 1);
    ovr_clr = 1'b1; tick(1); ovr_clr = 1'b0;
    check(ovr_flag == 0, "R8", "flag cleared", ovr_flag, 0);

    // R8 overrun, overwrite
    write_cfg(mk(2'd0, 1, 0, 0, 0, 0, 0));
    dout_ready = 1'b0;
    push(6, 0);
    pulse_start();
    tick(30);
    check(ovr_flag == 1, "R8", "overrun flag (overwrite)", ovr_flag, 1);
    check(dout_data == raw_of(6), "R8", "overwritten data", dout_data, raw_of(6));
    dout_ready = 1'b1; tick(2);
    check(exp_ch.size() == 0, "R11", "overwrite result read", exp_ch.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule